// File: doc/BRIEF.md
# Doorbell Interrupt Hub for Multiple Agents

This block lets up to eleven processing agents ring doorbells at one another over a shared register bus. Each agent owns a small register window, picked by a window-select field on the bus. Inside its own window an agent can ring one or more other agents. It can watch its own unanswered requests, read and answer the requests aimed at it, and mask or unmask each source of its interrupt.

Each agent is named by one fixed bit of a sparse 32-bit mask. That same bit is used in every register. When agent A rings agent B, the hub records one pending pair. The pair shows as bit B in A's outbound-busy view and as bit A in B's status view. B answers by writing 1 to bit A of its status register, and both views clear together. Some agents are marked secure-only. Their windows reject any access that does not carry the secure qualifier.

The bus is a plain register port with no handshake. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from the current select and offset. The bus never stalls, so there is no back-pressure and no valid/ready pair. Each agent has one interrupt output.

Top module: `ipi_hub`

## Requirements
- R1: Agent index i has a fixed bit in all 32-bit registers: agent 0 uses bit 0, agents 1–2 use bits 8–9, agents 3–6 use bits 16–19 and agents 7–10 use bits 24–27. Write-data bits outside these positions are ignored, and they read as 0.
- R2: A write to offset 0x00 (ring) of window A with bit B set marks pair (A,B) as pending from the next cycle. Bit B of A's outbound-busy register (offset 0x04) then reads 1, and bit A of B's status register (offset 0x10) reads 1. Several targets may be rung in one write.
- R3: Writing 1 to bit A of B's status register clears pair (A,B). Both views clear in the same cycle. Writing 0 bits has no effect.
- R4: The mask register (offset 0x14) resets to 1 on every agent bit. Writing 1 at offset 0x18 clears that mask bit, which unmasks it. Writing 1 at offset 0x1C sets it. Zero bits leave the mask unchanged.
- R5: An agent's interrupt output is a register holding the OR of its unmasked status bits. It changes exactly one cycle after the status or mask change.
- R6: Agents 3, 5 and 6 (bits 16, 18 and 19) are secure-only. When `bus_secure` is 0, reads of their windows return 0 and writes to them are ignored.
- R7: A window select of 11 or more, or an offset not listed in R2–R4, reads 0 and ignores writes. The write-only offsets 0x00, 0x18 and 0x1C also read 0.
- R8: Outbound-busy (0x04) and mask (0x14) are read-only. Writes to them change nothing.
- R9: During and after reset, no pair is pending and every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 4 | Agent window select |
| bus_off | input | 8 | Byte offset inside the window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_secure | input | 1 | Access carries secure qualification |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 11 | Interrupt per agent, indexed by agent number |

## Verification
The assertions assume that the bus inputs hold known 0/1 values whenever reset is released. They also rely on the fact that only one window is written per cycle, which the single shared port guarantees. Because of that, a ring and an answer never reach the pending state in the same edge. The bench drives every bus field at the falling edge and returns `bus_we` to 0 after one cycle. As a result, each edge sees at most one well-defined access. Deliberately illegal selects and offsets are still in-range bit patterns, never X.

// File: rtl/ipi_hub_pkg.sv
package ipi_hub_pkg;

  localparam int unsigned MAX_AGENTS = 11;
  localparam int unsigned WORD_W     = 32;

  localparam logic [7:0] OFF_RING = 8'h00;
  localparam logic [7:0] OFF_BUSY = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_MASK = 8'h14;
  localparam logic [7:0] OFF_UNMK = 8'h18;
  localparam logic [7:0] OFF_MSK1 = 8'h1C;

  // agents 3, 5, 6 accept secure traffic only
  localparam logic [MAX_AGENTS-1:0] SECURE_AGENTS = 11'b000_0110_1000;

  // sparse bit position of an agent inside every 32-bit register
  function automatic int unsigned agent_pos(int unsigned idx);
    if (idx == 0)      return 0;
    else if (idx < 3)  return idx + 7;
    else if (idx < 7)  return idx + 13;
    else               return idx + 17;
  endfunction

  function automatic logic [WORD_W-1:0] agent_map(int unsigned n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) m[agent_pos(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ipi_hub_decode.sv
module ipi_hub_decode
  import ipi_hub_pkg::*;
#(
  parameter int unsigned N     = 11,
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [7:0]       bus_off,
  input  logic             bus_we,
  input  logic             bus_secure,
  output logic [N-1:0]     win_hot,
  output logic             win_ok,
  output logic             wr_ring,
  output logic             wr_ack,
  output logic             wr_unmask,
  output logic             wr_mask
);

  logic in_rng;
  logic sec_hit;

  for (genvar i = 0; i < N; i++) begin : g_hot
    assign win_hot[i] = (bus_sel == SEL_W'(i));
  end

  assign in_rng  = (bus_sel < SEL_W'(N));
  assign sec_hit = |(win_hot & SECURE_AGENTS[N-1:0]);
  assign win_ok  = in_rng && (bus_secure || !sec_hit);

  assign wr_ring   = bus_we && win_ok && (bus_off == OFF_RING);
  assign wr_ack    = bus_we && win_ok && (bus_off == OFF_STAT);
  assign wr_unmask = bus_we && win_ok && (bus_off == OFF_UNMK);
  assign wr_mask   = bus_we && win_ok && (bus_off == OFF_MSK1);

endmodule

// File: rtl/ipi_hub_pend.sv
module ipi_hub_pend #(
  parameter int unsigned N = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        ring_hot,
  input  logic [N-1:0]        ack_hot,
  input  logic [N-1:0]        vec,
  output logic [N-1:0][N-1:0] pend_q
);

  // pend_q[a][b]: agent a has rung agent b and b has not answered
  for (genvar a = 0; a < N; a++) begin : g_src
    for (genvar b = 0; b < N; b++) begin : g_dst
      logic set_c, clr_c;
      assign set_c = ring_hot[a] && vec[b];
      assign clr_c = ack_hot[b] && vec[a];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q[a][b] <= 1'b0;
        else if (set_c)  pend_q[a][b] <= 1'b1;   // ring beats answer
        else if (clr_c)  pend_q[a][b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ipi_hub_irq.sv
module ipi_hub_irq #(
  parameter int unsigned N = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        unmask_hot,
  input  logic [N-1:0]        mask_hot,
  input  logic [N-1:0]        vec,
  input  logic [N-1:0][N-1:0] status,
  output logic [N-1:0][N-1:0] mask_q,
  output logic [N-1:0]        irq_o
);

  for (genvar b = 0; b < N; b++) begin : g_agent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= '1;
        irq_o[b]  <= 1'b0;
      end else begin
        if (unmask_hot[b])    mask_q[b] <= mask_q[b] & ~vec;
        else if (mask_hot[b]) mask_q[b] <= mask_q[b] | vec;
        irq_o[b] <= |(status[b] & ~mask_q[b]);
      end
    end
  end

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_hub_pkg::*;
#(
  parameter int unsigned N     = 11,
  parameter int unsigned SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic [7:0]        bus_off,
  input  logic              bus_we,
  input  logic              bus_secure,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [N-1:0]      irq_o
);

  localparam logic [WORD_W-1:0] MAP = agent_map(N);

  logic [N-1:0]        win_hot;
  logic                win_ok, wr_ring, wr_ack, wr_unmask, wr_mask;
  logic [N-1:0]        vec;
  logic [N-1:0][N-1:0] pend_q, status, mask_q;
  logic [N-1:0]        busy_sel, stat_sel, mask_sel;
  logic                unused_wbits;

  ipi_hub_decode #(.N(N), .SEL_W(SEL_W)) u_dec (
    .bus_sel(bus_sel), .bus_off(bus_off), .bus_we(bus_we),
    .bus_secure(bus_secure), .win_hot(win_hot), .win_ok(win_ok),
    .wr_ring(wr_ring), .wr_ack(wr_ack), .wr_unmask(wr_unmask),
    .wr_mask(wr_mask)
  );

  for (genvar i = 0; i < N; i++) begin : g_vec
    assign vec[i] = bus_wdata[agent_pos(i)];
  end
  assign unused_wbits = ^(bus_wdata & ~MAP);

  ipi_hub_pend #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .ring_hot(win_hot & {N{wr_ring}}),
    .ack_hot(win_hot & {N{wr_ack}}),
    .vec(vec), .pend_q(pend_q)
  );

  for (genvar b = 0; b < N; b++) begin : g_tr_b
    for (genvar a = 0; a < N; a++) begin : g_tr_a
      assign status[b][a] = pend_q[a][b];
    end
  end

  ipi_hub_irq #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .unmask_hot(win_hot & {N{wr_unmask}}),
    .mask_hot(win_hot & {N{wr_mask}}),
    .vec(vec), .status(status), .mask_q(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    busy_sel = '0;
    stat_sel = '0;
    mask_sel = '0;
    for (int i = 0; i < N; i++) begin
      busy_sel |= pend_q[i] & {N{win_hot[i]}};
      stat_sel |= status[i] & {N{win_hot[i]}};
      mask_sel |= mask_q[i] & {N{win_hot[i]}};
    end
  end

  function automatic logic [WORD_W-1:0] spread(logic [N-1:0] v);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned i = 0; i < N; i++) w[agent_pos(i)] = v[i];
    return w;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (win_ok) begin
      case (bus_off)
        OFF_BUSY: bus_rdata = spread(busy_sel);
        OFF_STAT: bus_rdata = spread(stat_sel);
        OFF_MASK: bus_rdata = spread(mask_sel);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk
  import ipi_hub_pkg::*;
#(
  parameter int unsigned N     = 11,
  parameter int unsigned SEL_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SEL_W-1:0]    bus_sel,
  input logic [7:0]          bus_off,
  input logic                bus_we,
  input logic                bus_secure,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic [N-1:0]        irq_o,
  input logic [N-1:0][N-1:0] pend_q,
  input logic [N-1:0][N-1:0] mask_q
);

  localparam logic [WORD_W-1:0] MAP = agent_map(N);

  logic [MAX_AGENTS-1:0] sec_sh;
  logic                  sec_win, ok;
  assign sec_sh  = SECURE_AGENTS >> bus_sel;
  assign sec_win = sec_sh[0];
  assign ok      = (bus_sel < SEL_W'(N)) && (bus_secure || !sec_win);

  // R1: unmapped bits never read back
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~MAP) == '0);

  // R6: refused window reads zero and writes leave state alone
  assert_secure_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_secure && sec_win) |-> bus_rdata == '0);
  assert_secure_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !ok) |=> ($stable(pend_q) && $stable(mask_q)));

  for (genvar b = 0; b < N; b++) begin : g_b
    logic [N-1:0] col;
    for (genvar a = 0; a < N; a++) begin : g_col
      assign col[a] = pend_q[a][b];
      // R2: ring marks pair pending next cycle
      assert_ring_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ok && bus_off == OFF_RING && bus_sel == SEL_W'(a)
         && bus_wdata[agent_pos(b)]) |=> pend_q[a][b]);
      // R3: answer clears the pair
      assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ok && bus_off == OFF_STAT && bus_sel == SEL_W'(b)
         && bus_wdata[agent_pos(a)]) |=> !pend_q[a][b]);
    end
    // R5: interrupt follows unmasked status one cycle later
    assert_irq_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[b] == $past(|(col & ~mask_q[b])));
  end

endmodule

bind ipi_hub ipi_hub_chk #(.N(N), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_off(bus_off),
  .bus_we(bus_we), .bus_secure(bus_secure), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/ipi_hub_tb_top.sv
module ipi_hub_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALL_AGENTS = 32'h0F0F_0301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_sel = '0;
  logic [7:0]  bus_off = '0;
  logic        bus_we = 1'b0;
  logic        bus_secure = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] irq_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_hub dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_off(bus_off),
    .bus_we(bus_we), .bus_secure(bus_secure), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [7:0] off, logic [31:0] d, logic sec);
    @(negedge clk);
    bus_sel = 4'(sel); bus_off = off; bus_wdata = d;
    bus_secure = sec; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(int sel, logic [7:0] off, logic sec, output logic [31:0] d);
    bus_we = 1'b0; bus_sel = 4'(sel); bus_off = off; bus_secure = sec;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    rd(0, 8'h04, 1'b1, rv); check("R9 busy after reset", rv, 32'h0);
    rd(4, 8'h10, 1'b1, rv); check("R9 status after reset", rv, 32'h0);
    rd(0, 8'h14, 1'b1, rv); check("R4 mask reset", rv, ALL_AGENTS);
    check("R9 irq after reset", 32'(irq_o), 32'h0);
  endtask

  task automatic t_ring_ack();
    wr(0, 8'h00, 32'h0000_01F0, 1'b0);        // agent0 rings agent1, junk bits 4-7
    rd(0, 8'h04, 1'b0, rv); check("R1 R2 busy of agent0", rv, 32'h0000_0100);
    rd(1, 8'h10, 1'b0, rv); check("R2 status of agent1", rv, 32'h0000_0001);
    wr(1, 8'h18, 32'h0000_0001, 1'b0);        // unmask source agent0
    rd(1, 8'h14, 1'b0, rv); check("R4 unmask", rv, ALL_AGENTS & ~32'h1);
    check("R5 irq not yet", 32'(irq_o[1]), 32'h0);
    @(negedge clk);
    check("R5 irq one cycle later", 32'(irq_o[1]), 32'h1);
    wr(1, 8'h10, 32'h0000_0000, 1'b0);
    rd(1, 8'h10, 1'b0, rv); check("R3 zero ack no effect", rv, 32'h1);
    wr(1, 8'h10, 32'h0000_0001, 1'b0);
    rd(0, 8'h04, 1'b0, rv); check("R3 busy cleared", rv, 32'h0);
    rd(1, 8'h10, 1'b0, rv); check("R3 status cleared", rv, 32'h0);
    check("R5 irq still high", 32'(irq_o[1]), 32'h1);
    @(negedge clk);
    check("R5 irq falls", 32'(irq_o[1]), 32'h0);
    wr(1, 8'h1C, 32'h0000_0001, 1'b0);
    rd(1, 8'h14, 1'b0, rv); check("R4 mask again", rv, ALL_AGENTS);
  endtask

  task automatic t_multi();
    wr(10, 8'h00, 32'h0100_0201, 1'b0);       // agent10 rings 0, 2, 7
    rd(10, 8'h04, 1'b0, rv); check("R2 multi busy", rv, 32'h0100_0201);
    rd(0, 8'h10, 1'b0, rv);  check("R2 multi status agent0", rv, 32'h0800_0000);
    rd(7, 8'h10, 1'b0, rv);  check("R2 multi status agent7", rv, 32'h0800_0000);
    wr(2, 8'h10, 32'h0800_0000, 1'b0);
    rd(10, 8'h04, 1'b0, rv); check("R3 partial clear", rv, 32'h0100_0001);
    rd(0, 8'h14, 1'b0, rv);  check("R5 masked source", 32'(irq_o[0]), 32'h0);
  endtask

  task automatic t_secure();
    wr(3, 8'h00, 32'h0000_0001, 1'b0);        // refused
    rd(3, 8'h04, 1'b1, rv); check("R6 nonsecure write ignored", rv, 32'h0);
    rd(3, 8'h14, 1'b0, rv); check("R6 nonsecure read zero", rv, 32'h0);
    rd(3, 8'h14, 1'b1, rv); check("R6 secure read", rv, ALL_AGENTS);
    wr(3, 8'h00, 32'h0000_0001, 1'b1);
    rd(0, 8'h10, 1'b0, rv); check("R6 secure ring", rv, 32'h0801_0000);
    wr(4, 8'h00, 32'h0000_0001, 1'b0);        // agent4 is open
    rd(4, 8'h04, 1'b0, rv); check("R6 open window", rv, 32'h1);
  endtask

  task automatic t_illegal();
    wr(12, 8'h00, 32'h0000_0001, 1'b1);
    rd(0, 8'h10, 1'b1, rv); check("R7 out-of-range write", rv, 32'h0803_0000);
    rd(12, 8'h14, 1'b1, rv); check("R7 out-of-range read", rv, 32'h0);
    rd(0, 8'h08, 1'b1, rv);  check("R7 undefined offset", rv, 32'h0);
    rd(0, 8'h00, 1'b1, rv);  check("R7 write-only reads zero", rv, 32'h0);
    wr(4, 8'h04, 32'hFFFF_FFFF, 1'b1);
    rd(4, 8'h04, 1'b1, rv); check("R8 busy read-only", rv, 32'h1);
    wr(4, 8'h14, 32'h0000_0000, 1'b1);
    rd(4, 8'h14, 1'b1, rv); check("R8 mask read-only", rv, ALL_AGENTS);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ring_ack();
    t_multi();
    t_secure();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule